// File: doc/BRIEF.md
# Two-Rate Link Speed Negotiation Controller

This controller brings a point-to-point serial link to a data rate that both ends can use, when each end supports a low rate, a high rate or both. It drives the local transmit-rate select and receive-rate select independently. After reset it always transmits at the high rate. It then searches the receive side, holding each receive rate for a programmable dwell, until the receive path reports intelligible data. The transmit select is then set to the rate at which data was found. A confirmation dwell follows, and the link is declared locked only if data is still valid at its end.

Once locked, the controller watches the receive data-valid indication. If that indication stays low for a programmable number of consecutive cycles, negotiation restarts from the initial state. Two nodes that both run this procedure settle on the high rate when both support it, and on the low rate when either end supports only the low rate. Neither end needs a common lowest-rate default. The validity detector itself lies outside this block and appears only as an input.

Top module: `rate_negotiator`

## Requirements
- R1: During and right after reset, tx_hi=1, rx_hi=0, locked=0 and rate_hi=0. Encoding: 1 selects the high rate and 0 selects the low rate.
- R2: While searching with data_ok low, rx_hi holds each value for exactly max(dwell_len,1) clock cycles and then toggles. It starts at low and wraps low, high, low, and so on.
- R3: When data_ok is sampled high while searching, tx_hi takes the current rx_hi value on the next clock edge, and rx_hi does not change.
- R4: locked rises max(dwell_len,1) clock edges after the edge that sampled the data hit, provided data_ok is high at the last of those edges.
- R5: If data_ok is low at the last edge of the confirmation dwell, the controller returns to the R1 state (tx_hi=1, rx_hi=0, locked=0).
- R6: With a partner that transmits at the high rate (data_ok equals rx_hi), the controller locks with tx_hi=1, rx_hi=1 and rate_hi=1.
- R7: With a partner that supports only the low rate (data_ok equals not rx_hi), tx_hi drops to 0 after valid low-rate data is received, and the lock reports rate_hi=0.
- R8: When locked, loss_len consecutive cycles (at least one) with data_ok low restart negotiation in the R1 state. A shorter gap followed by a high data_ok leaves the lock in place.
- R9: rate_hi is 0 whenever locked is 0, and equals tx_hi while locked is 1.
- R10: A dwell_len of 0 behaves as a dwell of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts negotiation |
| data_ok | input | 1 | Receive path reports intelligible data at the current receive rate |
| dwell_len | input | CNT_W | Cycles per receive-rate trial and per confirmation |
| loss_len | input | CNT_W | Consecutive invalid cycles that break a lock |
| tx_hi | output | 1 | Transmit rate select, 1 = high |
| rx_hi | output | 1 | Receive rate select, 1 = high |
| locked | output | 1 | Link rate settled and confirmed |
| rate_hi | output | 1 | Negotiated rate, 1 = high; 0 when not locked |

## Verification
The hardest case to reach is a confirmation that fails. In this case data appears during the search and then vanishes exactly before the end of the confirmation dwell, so the controller must go back to its reset state rather than lock. A partner model that follows rx_hi cannot produce this, so the bench drives data_ok by hand: high for the hit edge, then low until the dwell expires. The loss timeout is reached in a similar way. The bench swaps the partner model for a silent one for a counted gap one cycle short of the limit and then for the full limit.

// File: rtl/rate_neg_pkg.sv
package rate_neg_pkg;

  typedef enum logic [1:0] {
    NG_SEARCH  = 2'd0,
    NG_CONFIRM = 2'd1,
    NG_LOCKED  = 2'd2
  } neg_state_t;

  // A programmed length of zero is treated as one cycle.
  function automatic logic [31:0] span_of(input logic [31:0] len);
    return (len == 32'd0) ? 32'd1 : len;
  endfunction

  // True on the final cycle of a window of span_of(len) cycles.
  function automatic logic is_last(input logic [31:0] cnt, input logic [31:0] len);
    return cnt == (span_of(len) - 32'd1);
  endfunction

endpackage

// File: rtl/rate_neg_timer.sv
module rate_neg_timer
  import rate_neg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  assign expire = run && is_last(32'(cnt), 32'(len));

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (clr || expire)   cnt <= '0;
    else if (run)             cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/rate_neg_fsm.sv
module rate_neg_fsm
  import rate_neg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_ok,
  input  logic       expire,
  output neg_state_t state,
  output logic       tx_hi,
  output logic       rx_hi,
  output logic       tmr_clr,
  output logic       tmr_run,
  output logic       use_loss,
  output logic       hit,
  output logic       restart
);

  always_comb begin
    hit      = (state == NG_SEARCH) && data_ok;
    restart  = expire && (((state == NG_CONFIRM) && !data_ok) || (state == NG_LOCKED));
    use_loss = (state == NG_LOCKED);
    tmr_run  = use_loss ? !data_ok : 1'b1;
    tmr_clr  = hit || (use_loss && data_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      state <= NG_SEARCH;
      tx_hi <= 1'b1;
      rx_hi <= 1'b0;
    end else begin
      case (state)
        NG_SEARCH: begin
          if (hit) begin
            tx_hi <= rx_hi;
            state <= NG_CONFIRM;
          end else if (expire) begin
            rx_hi <= ~rx_hi;
          end
        end
        NG_CONFIRM: if (expire) state <= NG_LOCKED;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rate_negotiator.sv
module rate_negotiator
  import rate_neg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_ok,
  input  logic [CNT_W-1:0] dwell_len,
  input  logic [CNT_W-1:0] loss_len,
  output logic             tx_hi,
  output logic             rx_hi,
  output logic             locked,
  output logic             rate_hi
);

  neg_state_t       state;
  logic             expire, tmr_clr, tmr_run, use_loss, hit, restart;
  logic             dwell_end, in_search;
  logic [CNT_W-1:0] win_len;

  assign win_len   = use_loss ? loss_len : dwell_len;
  assign dwell_end = expire && !use_loss;
  assign in_search = (state == NG_SEARCH);

  rate_neg_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run),
    .len(win_len), .expire(expire)
  );

  rate_neg_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .data_ok(data_ok), .expire(expire),
    .state(state), .tx_hi(tx_hi), .rx_hi(rx_hi), .tmr_clr(tmr_clr),
    .tmr_run(tmr_run), .use_loss(use_loss), .hit(hit), .restart(restart)
  );

  assign locked  = (state == NG_LOCKED);
  assign rate_hi = locked & tx_hi;

endmodule

// File: rtl/rate_neg_checker.sv
module rate_neg_checker (
  input logic clk,
  input logic rst_n,
  input logic data_ok,
  input logic tx_hi,
  input logic rx_hi,
  input logic locked,
  input logic rate_hi,
  input logic hit,
  input logic dwell_end,
  input logic restart,
  input logic in_search
);

  p_tx_high_search_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_search |-> tx_hi);

  p_rx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_search && !dwell_end) |=> $stable(rx_hi));

  p_rx_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_search && dwell_end && !hit) |=> (rx_hi != $past(rx_hi)));

  p_tx_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (tx_hi == $past(rx_hi)) && $stable(rx_hi));

  p_lock_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(data_ok));

  p_restart_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> in_search && tx_hi && !rx_hi && !locked && !rate_hi);

endmodule

bind rate_negotiator rate_neg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .data_ok(data_ok), .tx_hi(tx_hi),
  .rx_hi(rx_hi), .locked(locked), .rate_hi(rate_hi), .hit(hit),
  .dwell_end(dwell_end), .restart(restart), .in_search(in_search)
);

// File: tb/rate_negotiator_tb.sv
`timescale 1ns/1ps
module rate_negotiator_tb;

  localparam int CNT_W = 16;
  localparam logic [1:0] PT_NONE = 2'd0, PT_BOTH = 2'd1, PT_LOW = 2'd2, PT_MAN = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] dwell_len = 16'd4, loss_len = 16'd8;
  logic [1:0] mode = PT_NONE;
  logic man = 1'b0;
  logic data_ok, tx_hi, rx_hi, locked, rate_hi;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // Partner model: which receive rate yields intelligible data
  assign data_ok = (mode == PT_BOTH) ? rx_hi :
                   (mode == PT_LOW)  ? !rx_hi :
                   (mode == PT_MAN)  ? man : 1'b0;

  rate_negotiator #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .data_ok(data_ok), .dwell_len(dwell_len),
    .loss_len(loss_len), .tx_hi(tx_hi), .rx_hi(rx_hi), .locked(locked),
    .rate_hi(rate_hi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart_dut(input logic [CNT_W-1:0] d, input logic [CNT_W-1:0] l,
                             input logic [1:0] m, input logic mv);
    @(negedge clk);
    rst_n = 1'b0; dwell_len = d; loss_len = l; mode = m; man = mv;
    step(2);
    chk("R1 tx_hi in reset", tx_hi, 1);
    chk("R1 rx_hi in reset", rx_hi, 0);
    chk("R1 locked in reset", locked, 0);
    chk("R9 rate_hi in reset", rate_hi, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_dwell();
    restart_dut(16'd3, 16'd8, PT_NONE, 1'b0);
    step(2); chk("R2 rx low before dwell end", rx_hi, 0);
    step(1); chk("R2 rx high after dwell", rx_hi, 1);
    chk("R1 tx stays high while searching", tx_hi, 1);
    step(2); chk("R2 rx high mid dwell", rx_hi, 1);
    step(1); chk("R2 rx wraps to low", rx_hi, 0);
    chk("R9 rate_hi unlocked", rate_hi, 0);
    restart_dut(16'd0, 16'd8, PT_NONE, 1'b0);
    step(1); chk("R10 zero dwell toggles after one", rx_hi, 1);
    step(1); chk("R10 zero dwell toggles back", rx_hi, 0);
  endtask

  task automatic t_both();
    restart_dut(16'd4, 16'd8, PT_BOTH, 1'b0);
    step(4); chk("R6 rx moved to high", rx_hi, 1);
    chk("R6 not yet locked", locked, 0);
    step(1); chk("R3 tx equals rx high", tx_hi, 1);
    step(3); chk("R4 not locked before confirm end", locked, 0);
    chk("R9 rate_hi zero before lock", rate_hi, 0);
    step(1); chk("R4 locked after confirm", locked, 1);
    chk("R6 rate_hi high", rate_hi, 1);
    chk("R6 tx_hi high", tx_hi, 1);
  endtask

  task automatic t_low();
    restart_dut(16'd4, 16'd8, PT_LOW, 1'b0);
    step(1); chk("R7 tx dropped to low", tx_hi, 0);
    chk("R3 rx unchanged on hit", rx_hi, 0);
    step(3); chk("R4 not locked early", locked, 0);
    step(1); chk("R7 locked at low rate", locked, 1);
    chk("R7 rate_hi low", rate_hi, 0);
    chk("R9 rate_hi equals tx_hi", rate_hi, tx_hi);
  endtask

  task automatic t_confirm_fail();
    restart_dut(16'd3, 16'd8, PT_MAN, 1'b1);
    step(1); chk("R3 hit at low sets tx low", tx_hi, 0);
    man = 1'b0;
    step(2); chk("R5 still confirming", tx_hi, 0);
    chk("R5 not locked", locked, 0);
    step(1); chk("R5 tx back high", tx_hi, 1);
    chk("R5 rx back low", rx_hi, 0);
    chk("R5 no lock", locked, 0);
  endtask

  task automatic t_loss();
    restart_dut(16'd2, 16'd5, PT_LOW, 1'b0);
    step(3); chk("R8 locked before loss", locked, 1);
    mode = PT_NONE;
    step(4); chk("R8 short gap keeps lock", locked, 1);
    mode = PT_LOW;
    step(1); chk("R8 lock after recovery", locked, 1);
    mode = PT_NONE;
    step(4); chk("R8 gap restarted from zero", locked, 1);
    step(1); chk("R8 lock lost at limit", locked, 0);
    chk("R8 tx back high", tx_hi, 1);
    chk("R8 rx back low", rx_hi, 0);
  endtask

  initial begin
    t_dwell();
    t_both();
    t_low();
    t_confirm_fail();
    t_loss();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule